// File: doc/BRIEF.md
# Multi-Port Register File with Constant Entries

This block is the architectural register storage of a wide-issue datapath. It holds 128 words of 32 bits. Entry 0 is fixed at the value zero, which also serves as boolean false and as floating-point +0.0. Entry 1 is fixed at the value one, which also serves as boolean true. Entries 2 to 127 are plain storage that the hardware assigns no role to.

Ten read ports return their words combinationally, with no clock between address and data. Five write ports commit on the rising clock edge. When several write ports aim at the same entry in one cycle, the highest-numbered port decides the stored value. A write aimed at entry 0 or 1 is discarded, so the constants cannot be disturbed in that cycle or in any other. Such a write also raises a sticky error flag, which stays high until software-side logic clears it through a dedicated input.

Top module: `rf_const_top`

## Requirements
- R1: A write on any write port to an address from 2 to 127 is stored at the rising edge. From the next cycle every read port that selects that address returns the written 32-bit value.
- R2: A read port that selects address 0 returns 0x00000000 in every cycle after reset, including the cycle in which a write targets address 0 and the cycle after it.
- R3: A read port that selects address 1 returns 0x00000001 in every cycle after reset, including the cycle in which a write targets address 1 and the cycle after it.
- R4: A write enabled toward address 0 or 1 changes no stored entry. A value held in entries 2 to 127 is still read back after such a write.
- R5: `illegal_flag` goes high in the cycle after any enabled write port carries address 0 or 1. It then stays high until it is cleared.
- R6: With `illegal_clr` high and no write to address 0 or 1 in the same cycle, `illegal_flag` is low in the next cycle. If both happen in the same cycle, the flag is high in the next cycle.
- R7: When two or more enabled write ports name the same address in one cycle, the entry takes the data of the highest-numbered of those ports.
- R8: A read of an address in the same cycle as a write to it returns the value held before that write.
- R9: Synchronous reset drives `illegal_flag` low. Reset does not clear entries 2 to 127, so a value written before reset reads back after it.
- R10: The read ports are independent. All ten may select different addresses in one cycle, and each returns its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 5 | Per-port write enable, bit p for port p |
| wr_addr | input | 5x7 | Per-port write address |
| wr_data | input | 5x32 | Per-port write data |
| rd_addr | input | 10x7 | Per-port read address |
| rd_data | output | 10x32 | Per-port read data, combinational |
| illegal_clr | input | 1 | Clears the sticky illegal-write flag |
| illegal_flag | output | 1 | Sticky flag for a write aimed at entry 0 or 1 |

## Verification
Read data is combinational, so the bench sets a read address and samples the data one time unit later in the same cycle. The read data for a write becomes valid one rising edge after that write is driven. The bench therefore drives a write at the falling edge, lets one rising edge pass, and reads in the low phase that follows. The same-cycle check for R8 samples before that edge. The illegal flag is a register, and it is checked in the low phase after the edge that follows the offending write or the clear.

// File: rtl/rf_const_pkg.sv
package rf_const_pkg;
    localparam int RF_DEPTH  = 128;
    localparam int RF_WIDTH  = 32;
    localparam int RF_WPORTS = 5;
    localparam int RF_RPORTS = 10;
    localparam int RF_AW     = $clog2(RF_DEPTH);
    localparam int RF_NCONST = 2;

    typedef logic [RF_AW-1:0]    rf_addr_t;
    typedef logic [RF_WIDTH-1:0] rf_word_t;

    typedef struct packed {
        logic     en;
        rf_word_t data;
    } rf_upd_t;

    function automatic logic is_const_addr(input rf_addr_t a);
        return a < rf_addr_t'(RF_NCONST);
    endfunction

    function automatic rf_word_t const_value(input int idx);
        return rf_word_t'(idx);
    endfunction
endpackage

// File: rtl/rf_entry_wsel.sv
module rf_entry_wsel
    import rf_const_pkg::*;
#(
    parameter int NW  = RF_WPORTS,
    parameter int IDX = 2
) (
    input  logic     [NW-1:0]          wr_en,
    input  rf_addr_t [NW-1:0]          wr_addr,
    input  rf_word_t [NW-1:0]          wr_data,
    output rf_upd_t                    upd
);
    always_comb begin
        upd = '0;
        for (int p = 0; p < NW; p++) begin
            if (wr_en[p] && wr_addr[p] == rf_addr_t'(IDX)) begin
                upd.en   = 1'b1;
                upd.data = wr_data[p];
            end
        end
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import rf_const_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH,
    parameter int NW    = RF_WPORTS
) (
    input  logic                       clk,
    input  logic     [NW-1:0]          wr_en,
    input  rf_addr_t [NW-1:0]          wr_addr,
    input  rf_word_t [NW-1:0]          wr_data,
    output rf_word_t [DEPTH-1:0]       entries
);
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            if (g < RF_NCONST) begin : g_const
                assign entries[g] = const_value(g);
            end else begin : g_store
                rf_upd_t  upd;
                rf_word_t q;
                rf_entry_wsel #(.NW(NW), .IDX(g)) u_wsel (
                    .wr_en  (wr_en),
                    .wr_addr(wr_addr),
                    .wr_data(wr_data),
                    .upd    (upd)
                );
                always_ff @(posedge clk) begin
                    if (upd.en) q <= upd.data;
                end
                assign entries[g] = q;
            end
        end
    endgenerate
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
    import rf_const_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH
) (
    input  rf_word_t [DEPTH-1:0] entries,
    input  rf_addr_t             addr,
    output rf_word_t             data
);
    always_comb data = entries[addr];
endmodule

// File: rtl/rf_illegal_mon.sv
module rf_illegal_mon
    import rf_const_pkg::*;
#(
    parameter int NW = RF_WPORTS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic     [NW-1:0]   wr_en,
    input  rf_addr_t [NW-1:0]   wr_addr,
    input  logic                clr,
    output logic                flag
);
    logic hit;
    always_comb begin
        hit = 1'b0;
        for (int p = 0; p < NW; p++)
            if (wr_en[p] && is_const_addr(wr_addr[p])) hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/rf_const_top.sv
module rf_const_top
    import rf_const_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH,
    parameter int NW    = RF_WPORTS,
    parameter int NR    = RF_RPORTS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NW-1:0]              wr_en,
    input  logic [NW-1:0][RF_AW-1:0]   wr_addr,
    input  logic [NW-1:0][RF_WIDTH-1:0] wr_data,
    input  logic [NR-1:0][RF_AW-1:0]   rd_addr,
    output logic [NR-1:0][RF_WIDTH-1:0] rd_data,
    input  logic                       illegal_clr,
    output logic                       illegal_flag
);
    rf_word_t [DEPTH-1:0] entries;

    rf_bank #(.DEPTH(DEPTH), .NW(NW)) u_bank (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .entries(entries)
    );

    genvar r;
    generate
        for (r = 0; r < NR; r++) begin : g_rd
            rf_rd_port #(.DEPTH(DEPTH)) u_rd (
                .entries(entries),
                .addr   (rd_addr[r]),
                .data   (rd_data[r])
            );
        end
    endgenerate

    rf_illegal_mon #(.NW(NW)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .clr    (illegal_clr),
        .flag   (illegal_flag)
    );
endmodule

// File: rtl/rf_const_chk.sv
module rf_const_chk
    import rf_const_pkg::*;
#(
    parameter int NW = RF_WPORTS,
    parameter int NR = RF_RPORTS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NW-1:0]               wr_en,
    input  logic [NW-1:0][RF_AW-1:0]    wr_addr,
    input  logic [NR-1:0][RF_AW-1:0]    rd_addr,
    input  logic [NR-1:0][RF_WIDTH-1:0] rd_data,
    input  logic                        illegal_clr,
    input  logic                        illegal_flag
);
    logic bad_wr;
    always_comb begin
        bad_wr = 1'b0;
        for (int p = 0; p < NW; p++)
            if (wr_en[p] && wr_addr[p] < RF_AW'(2)) bad_wr = 1'b1;
    end

    genvar r;
    generate
        for (r = 0; r < NR; r++) begin : g_rp
            // R2
            zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
                rd_addr[r] == '0 |-> rd_data[r] == '0);
            // R3
            one_entry_chk: assert property (@(posedge clk) disable iff (rst)
                rd_addr[r] == RF_AW'(1) |-> rd_data[r] == RF_WIDTH'(1));
        end
    endgenerate

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> illegal_flag);
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_flag && !illegal_clr |=> illegal_flag);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_clr && !bad_wr |=> !illegal_flag);
    // R9
    flag_reset_chk: assert property (@(posedge clk)
        rst |=> !illegal_flag);
endmodule

bind rf_const_top rf_const_chk #(.NW(NW), .NR(NR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .illegal_clr (illegal_clr),
    .illegal_flag(illegal_flag)
);

// File: tb/tb_rf_const_top.sv
module tb_rf_const_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 5;
    localparam int NR = 10;
    localparam int AW = 7;
    localparam int DW = 32;

    typedef struct packed {
        logic [2:0]    port;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 7'd2,   32'hDEAD_BEEF},
        '{3'd1, 7'd127, 32'h1234_5678},
        '{3'd2, 7'd64,  32'hFFFF_FFFF},
        '{3'd3, 7'd3,   32'h0000_0000},
        '{3'd4, 7'd100, 32'hA5A5_5A5A},
        '{3'd0, 7'd77,  32'h8000_0001},
        '{3'd2, 7'd5,   32'h0F0F_F0F0},
        '{3'd4, 7'd126, 32'h7654_3210}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0]          wr_en = '0;
    logic [NW-1:0][AW-1:0]  wr_addr = '0;
    logic [NW-1:0][DW-1:0]  wr_data = '0;
    logic [NR-1:0][AW-1:0]  rd_addr = '0;
    logic [NR-1:0][DW-1:0]  rd_data;
    logic illegal_clr = 1'b0;
    logic illegal_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_const_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .illegal_clr(illegal_clr), .illegal_flag(illegal_flag)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_one(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = '0;
        wr_en[p] = 1'b1;
        wr_addr[p] = a;
        wr_data[p] = d;
        cycle();
        wr_en = '0;
    endtask

    task automatic rd_chk(input int r, input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        rd_addr[r] = a;
        #1;
        check(req, rd_data[r], exp);
    endtask

    initial begin
        @(negedge clk);
        cycle();
        rst = 1'b0;
        #1;
        // R9 flag low after reset, R2/R3 constants from first cycle
        check("R9", {31'd0, illegal_flag}, 32'd0);
        rd_chk(0, 7'd0, 32'd0, "R2");
        rd_chk(1, 7'd1, 32'd1, "R3");
        @(negedge clk);

        // R1 table-driven write then read
        for (int i = 0; i < NVEC; i++) begin
            wr_one(int'(VECS[i].port), VECS[i].addr, VECS[i].data);
            rd_chk(i % NR, VECS[i].addr, VECS[i].data, "R1");
        end

        // R10 all ports read distinct entries at once
        for (int r = 0; r < NR; r++) rd_addr[r] = (r < NVEC) ? VECS[r].addr : AW'(r - NVEC);
        #1;
        for (int r = 0; r < NR; r++)
            check("R10", rd_data[r], (r < NVEC) ? VECS[r].data : DW'(r - NVEC));
        @(negedge clk);

        // R8 same-cycle read returns old value
        wr_en[3] = 1'b1; wr_addr[3] = 7'd2; wr_data[3] = 32'h1111_2222;
        rd_addr[5] = 7'd2;
        #1;
        check("R8", rd_data[5], 32'hDEAD_BEEF);
        cycle();
        wr_en = '0;
        rd_chk(5, 7'd2, 32'h1111_2222, "R8");

        // R7 conflict: ports 1,2,4 to entry 50 -> port 4 wins
        wr_en = 5'b10110;
        wr_addr[1] = 7'd50; wr_data[1] = 32'hAAAA_0001;
        wr_addr[2] = 7'd50; wr_data[2] = 32'hAAAA_0002;
        wr_addr[4] = 7'd50; wr_data[4] = 32'hAAAA_0004;
        cycle();
        wr_en = '0;
        rd_chk(0, 7'd50, 32'hAAAA_0004, "R7");
        // R7 ports 0 and 3 -> port 3 wins
        wr_en = 5'b01001;
        wr_addr[0] = 7'd51; wr_data[0] = 32'hBBBB_0000;
        wr_addr[3] = 7'd51; wr_data[3] = 32'hBBBB_0003;
        cycle();
        wr_en = '0;
        rd_chk(0, 7'd51, 32'hBBBB_0003, "R7");

        // R4/R2/R3/R5 illegal writes to constants
        check("R5", {31'd0, illegal_flag}, 32'd0);
        wr_en = 5'b00011;
        wr_addr[0] = 7'd0; wr_data[0] = 32'hFFFF_FFFF;
        wr_addr[1] = 7'd1; wr_data[1] = 32'hCAFE_F00D;
        rd_addr[2] = 7'd0; rd_addr[3] = 7'd1;
        #1;
        check("R2", rd_data[2], 32'd0);
        check("R3", rd_data[3], 32'd1);
        cycle();
        wr_en = '0;
        #1;
        check("R2", rd_data[2], 32'd0);
        check("R3", rd_data[3], 32'd1);
        check("R5", {31'd0, illegal_flag}, 32'd1);
        rd_chk(4, 7'd127, 32'h1234_5678, "R4");
        rd_chk(6, 7'd50, 32'hAAAA_0004, "R4");
        cycle();
        check("R5", {31'd0, illegal_flag}, 32'd1);

        // R6 clear
        illegal_clr = 1'b1;
        cycle();
        illegal_clr = 1'b0;
        #1;
        check("R6", {31'd0, illegal_flag}, 32'd0);
        @(negedge clk);
        // R6 set wins over clear
        illegal_clr = 1'b1;
        wr_en[2] = 1'b1; wr_addr[2] = 7'd1; wr_data[2] = 32'h5;
        cycle();
        illegal_clr = 1'b0;
        wr_en = '0;
        #1;
        check("R6", {31'd0, illegal_flag}, 32'd1);
        rd_chk(7, 7'd1, 32'd1, "R3");
        @(negedge clk);

        // R9 reset clears flag, keeps storage
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        #1;
        check("R9", {31'd0, illegal_flag}, 32'd0);
        rd_chk(8, 7'd100, 32'hA5A5_5A5A, "R9");
        rd_chk(9, 7'd0, 32'd0, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule